// File: doc/BRIEF.md
# Modem Handshake Auto-Enable Controller

This block manages the modem-control lines of one serial channel. It takes three active-low line inputs, which may arrive asynchronously: clear-to-send, carrier-detect and sync. Each one is resynchronised to the local clock. When the automatic-gating control is on, clear-to-send and carrier-detect directly switch the transmitter enable and the receiver enable. When it is off, both lines are plain status inputs.

The active-low request-to-send output follows the inverse of its control bit while automatic gating is off. While gating is on, a cleared request bit does not drop the line straight away. In asynchronous framing the line stays asserted until the transmitter reports that it is empty. In bit-oriented framing with the hold option set, it stays asserted until the closing flag has been shifted out.

Every input is watched for edges in both directions. Each edge sets a sticky change flag, and while the flag is set the reported level stays frozen. The enabled flags are ORed into one interrupt request, and a single acknowledge strobe clears all flags.

Top module: `modem_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `rts_no` is 1, `chg_o` is 0 and `irq_o` is 0, as long as no other input changes.
- R2: When `auto_en_i`=1, `tx_en_o` equals the inverse of `cts_ni` as it was two clock edges earlier. A low line enables the transmitter and a high line holds it off.
- R3: When `auto_en_i`=1, `rx_en_o` equals the inverse of `dcd_ni` as it was two clock edges earlier.
- R4: When `auto_en_i`=0, `tx_en_o` and `rx_en_o` are both 1, whatever the line levels.
- R5: When `auto_en_i`=0, `rts_no` equals the inverse of `rts_bit_i` from the previous clock edge.
- R6: When `auto_en_i`=1 and `async_mode_i`=1, an asserted request line stays low while `rts_bit_i`=0 and `tx_empty_i`=0. It goes high one edge after `tx_empty_i` is seen as 1.
- R7: When `auto_en_i`=1, `async_mode_i`=0, `bitsync_mode_i`=1 and `flag_hold_i`=1, an asserted request line with `rts_bit_i`=0 ignores `tx_empty_i`. It goes high one edge after the `flag_done_i` strobe.
- R8: When `auto_en_i`=1 and `rts_bit_i`=1, `rts_no` is 0 at the next edge. In any framing that is neither asynchronous nor bit-oriented with hold, clearing the bit releases the line at the next edge.
- R9: A line change in either direction on `cts_ni` (bit 0) or `dcd_ni` (bit 1) sets the matching `chg_o` bit three edges after the pin changes.
- R10: Edges on `sync_ni` set `chg_o[2]` only while `async_mode_i`=1. In other modes `chg_o[2]` stays 0.
- R11: `irq_o` is the OR over all bits of `chg_o & ie_i`. It follows `ie_i` without delay.
- R12: `ack_i` sampled high clears every `chg_o` bit at that edge. An edge that is detected at the same clock edge still sets its flag.
- R13: `stat_o[k]` is 1 when line k is low. While `chg_o[k]` is set, `stat_o[k]` holds the level that was captured when the change was detected. Once the flag clears, `stat_o[k]` shows the live level again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_ni | input | 1 | Clear-to-send line, active low |
| dcd_ni | input | 1 | Carrier-detect line, active low |
| sync_ni | input | 1 | Sync line, active low |
| auto_en_i | input | 1 | Automatic gating control |
| rts_bit_i | input | 1 | Request-to-send control bit |
| async_mode_i | input | 1 | Asynchronous framing selected |
| bitsync_mode_i | input | 1 | Bit-oriented framing selected |
| flag_hold_i | input | 1 | Hold request until the closing flag is sent |
| tx_empty_i | input | 1 | Transmitter empty level |
| flag_done_i | input | 1 | Strobe: closing flag has left the data pin |
| ack_i | input | 1 | Interrupt acknowledge; clears all change flags |
| ie_i | input | 3 | Per-source interrupt enables {sync, dcd, cts} |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| rts_no | output | 1 | Request-to-send line, active low |
| stat_o | output | 3 | Reported asserted levels {sync, dcd, cts} |
| chg_o | output | 3 | Latched change flags {sync, dcd, cts} |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change needs two edges to reach the enables and three edges to reach the change flags and the frozen status. Request-line updates and flag clearing by acknowledge take one edge. The interrupt output follows `ie_i` combinationally. The bench drives every stimulus on a falling clock edge and counts rising edges from that point. It checks the cycle just before each result is due as well as the cycle it is due, so an off-by-one in either direction shows up. The acknowledge test lines the strobe up with the edge that detects a new change, to check that the set takes priority over the clear.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  localparam int NSRC     = 3;
  localparam int CTS_IDX  = 0;
  localparam int DCD_IDX  = 1;
  localparam int SYNC_IDX = 2;

  typedef enum logic [1:0] {
    REL_NOW      = 2'd0,
    REL_TX_EMPTY = 2'd1,
    REL_FLAG     = 2'd2
  } rts_rel_e;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/modem_edge_latch.sv
module modem_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_ni,
  input  logic arm_i,
  input  logic ack_i,
  output logic chg_o,
  output logic stat_o
);
  logic prev_q, held_q, chg_q, edge_w;

  assign edge_w = arm_i && (lvl_ni != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      held_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      prev_q <= lvl_ni;
      // new edge beats acknowledge; first captured level is kept
      if (edge_w && !(chg_q && !ack_i)) held_q <= ~lvl_ni;
      if (edge_w)     chg_q <= 1'b1;
      else if (ack_i) chg_q <= 1'b0;
    end
  end

  assign chg_o  = chg_q;
  assign stat_o = chg_q ? held_q : ~lvl_ni;
endmodule

// File: rtl/modem_rts_ctl.sv
module modem_rts_ctl
  import modem_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_en_i,
  input  logic rts_bit_i,
  input  logic async_mode_i,
  input  logic bitsync_mode_i,
  input  logic flag_hold_i,
  input  logic tx_empty_i,
  input  logic flag_done_i,
  output logic rts_no
);
  rts_rel_e rel_w;
  logic     asrt_q, asrt_d, release_w;

  always_comb begin
    if (async_mode_i)                       rel_w = REL_TX_EMPTY;
    else if (bitsync_mode_i && flag_hold_i) rel_w = REL_FLAG;
    else                                    rel_w = REL_NOW;
  end

  always_comb begin
    unique case (rel_w)
      REL_TX_EMPTY: release_w = tx_empty_i;
      REL_FLAG:     release_w = flag_done_i;
      default:      release_w = 1'b1;
    endcase
  end

  always_comb begin
    if (!auto_en_i || rts_bit_i) asrt_d = rts_bit_i;
    else                         asrt_d = asrt_q && !release_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) asrt_q <= 1'b0;
    else         asrt_q <= asrt_d;
  end

  assign rts_no = ~asrt_q;
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import modem_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cts_ni,
  input  logic            dcd_ni,
  input  logic            sync_ni,
  input  logic            auto_en_i,
  input  logic            rts_bit_i,
  input  logic            async_mode_i,
  input  logic            bitsync_mode_i,
  input  logic            flag_hold_i,
  input  logic            tx_empty_i,
  input  logic            flag_done_i,
  input  logic            ack_i,
  input  logic [NSRC-1:0] ie_i,
  output logic            tx_en_o,
  output logic            rx_en_o,
  output logic            rts_no,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] chg_o,
  output logic            irq_o
);
  logic [NSRC-1:0] raw_w, lvl_w, arm_w;

  always_comb begin
    raw_w           = '1;
    raw_w[CTS_IDX]  = cts_ni;
    raw_w[DCD_IDX]  = dcd_ni;
    raw_w[SYNC_IDX] = sync_ni;
    arm_w           = '1;
    arm_w[SYNC_IDX] = async_mode_i;
  end

  modem_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_w),
    .q_o   (lvl_w)
  );

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    modem_edge_latch u_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_ni(lvl_w[k]),
      .arm_i (arm_w[k]),
      .ack_i (ack_i),
      .chg_o (chg_o[k]),
      .stat_o(stat_o[k])
    );
  end

  assign tx_en_o = !auto_en_i || !lvl_w[CTS_IDX];
  assign rx_en_o = !auto_en_i || !lvl_w[DCD_IDX];
  assign irq_o   = |(chg_o & ie_i);

  modem_rts_ctl u_rts (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .auto_en_i     (auto_en_i),
    .rts_bit_i     (rts_bit_i),
    .async_mode_i  (async_mode_i),
    .bitsync_mode_i(bitsync_mode_i),
    .flag_hold_i   (flag_hold_i),
    .tx_empty_i    (tx_empty_i),
    .flag_done_i   (flag_done_i),
    .rts_no        (rts_no)
  );
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk
  import modem_ctl_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            auto_en_i,
  input logic            rts_bit_i,
  input logic            async_mode_i,
  input logic            tx_empty_i,
  input logic            ack_i,
  input logic            tx_en_o,
  input logic            rx_en_o,
  input logic            rts_no,
  input logic [NSRC-1:0] chg_o,
  input logic            irq_o
);
  // R4
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |-> (tx_en_o && rx_en_o));

  // R5
  rts_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |=> (rts_no == !$past(rts_bit_i)));

  // R6
  rts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && async_mode_i && !rts_bit_i && !tx_empty_i && !rts_no) |=> !rts_no);

  // R8
  rts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && rts_bit_i) |=> !rts_no);

  // R11
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o == '0) |-> !irq_o);

  // R12
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(chg_o) & ~chg_o)) |-> $past(ack_i));
endmodule

bind modem_ctl modem_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .auto_en_i   (auto_en_i),
  .rts_bit_i   (rts_bit_i),
  .async_mode_i(async_mode_i),
  .tx_empty_i  (tx_empty_i),
  .ack_i       (ack_i),
  .tx_en_o     (tx_en_o),
  .rx_en_o     (rx_en_o),
  .rts_no      (rts_no),
  .chg_o       (chg_o),
  .irq_o       (irq_o)
);

// File: tb/modem_ctl_test.sv
`timescale 1ns/1ps
module modem_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n = 1, dcd_n = 1, sync_n = 1;
  logic auto_en = 0, rts_bit = 0, async_m = 0, bitsync_m = 0, fhold = 0;
  logic tx_empty = 0, fdone = 0, ack = 0;
  logic [2:0] ie = 3'b111;
  logic tx_en, rx_en, rts_n, irq;
  logic [2:0] stat, chg;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  modem_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .cts_ni(cts_n), .dcd_ni(dcd_n), .sync_ni(sync_n),
    .auto_en_i(auto_en), .rts_bit_i(rts_bit), .async_mode_i(async_m),
    .bitsync_mode_i(bitsync_m), .flag_hold_i(fhold), .tx_empty_i(tx_empty),
    .flag_done_i(fdone), .ack_i(ack), .ie_i(ie), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .rts_no(rts_n), .stat_o(stat), .chg_o(chg), .irq_o(irq)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic posn(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic neg;
    @(negedge clk);
  endtask

  task automatic clear_flags;
    neg(); ack = 1;
    neg(); ack = 0;
  endtask

  task automatic set_line(input int k, input logic v);
    if (k == 0) cts_n = v; else if (k == 1) dcd_n = v; else sync_n = v;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #40000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    posn(3);
    // R1 during reset
    chk({rts_n, irq, chg}, {1'b1, 1'b0, 3'b000}, "R1 in reset");
    neg(); rst_n = 1;
    posn(4);
    chk({rts_n, irq, chg}, {1'b1, 1'b0, 3'b000}, "R1 after reset");

    // R4/R5 sweep with gating off
    for (int v = 0; v < 8; v++) begin
      neg(); cts_n = v[0]; dcd_n = v[1]; rts_bit = v[2];
      posn(1);
      chk({3'b0, rts_n}, {3'b0, ~v[2]}, "R5 rts follows bit");
      posn(2);
      chk({2'b0, tx_en, rx_en}, 4'b0011, "R4 enables forced on");
    end
    neg(); cts_n = 1; dcd_n = 1; rts_bit = 0;
    posn(4);
    clear_flags();

    // R9/R13 on each of cts and dcd
    for (int k = 0; k < 2; k++) begin
      neg(); set_line(k, 0);
      posn(2);
      chk({3'b0, chg[k]}, 4'd0, "R9 not yet set");
      posn(1);
      chk({2'b0, chg[k], stat[k]}, 4'b0011, "R9 set on fall, R13 status");
      neg(); set_line(k, 1);
      posn(4);
      chk({3'b0, stat[k]}, 4'd1, "R13 frozen");
      neg(); ack = 1;
      posn(1);
      chk({2'b0, chg[k], stat[k]}, 4'b0000, "R12 cleared, R13 live");
      neg(); ack = 0; set_line(k, 0);
      posn(4);
      clear_flags();
      neg(); set_line(k, 1);
      posn(3);
      chk({2'b0, chg[k], stat[k]}, 4'b0010, "R9 set on rise");
      clear_flags();
    end

    // R2/R3 gating
    neg(); auto_en = 1;
    posn(1);
    chk({2'b0, tx_en, rx_en}, 4'b0000, "R2 R3 lines high hold off");
    for (int k = 0; k < 2; k++) begin
      neg(); set_line(k, 0);
      posn(1);
      chk({3'b0, (k == 0) ? tx_en : rx_en}, 4'd0, k == 0 ? "R2 one edge" : "R3 one edge");
      posn(1);
      chk({3'b0, (k == 0) ? tx_en : rx_en}, 4'd1, k == 0 ? "R2 enabled" : "R3 enabled");
      neg(); set_line(k, 1);
      posn(2);
      chk({3'b0, (k == 0) ? tx_en : rx_en}, 4'd0, k == 0 ? "R2 off again" : "R3 off again");
    end
    posn(3);
    clear_flags();

    // R11 irq over all enable masks, flags = 011
    neg(); cts_n = 0; dcd_n = 0;
    posn(4);
    for (int v = 0; v < 8; v++) begin
      neg(); ie = v[2:0];
      #1;
      chk({3'b0, irq}, {3'b0, |(v[2:0] & 3'b011)}, "R11 irq mask");
    end
    neg(); ie = 3'b111;
    clear_flags();

    // R10 sync qualified by async mode
    neg(); async_m = 0; sync_n = 0;
    posn(4);
    chk({3'b0, chg[2]}, 4'd0, "R10 ignored outside async");
    neg(); async_m = 1; sync_n = 1;
    posn(3);
    chk({3'b0, chg[2]}, 4'd1, "R10 set in async");
    clear_flags();

    // R12 set beats simultaneous ack
    neg(); dcd_n = 1;
    posn(4);
    chk({1'b0, chg}, 4'b0010, "R12 setup");
    neg(); cts_n = 1;
    posn(2);
    neg(); ack = 1;
    posn(1);
    chk({1'b0, chg}, 4'b0001, "R12 set wins over ack");
    neg(); ack = 0;
    clear_flags();

    // R6 async release on tx empty
    neg(); async_m = 1; rts_bit = 1; tx_empty = 0;
    posn(1);
    chk({3'b0, rts_n}, 4'd0, "R8 asserted");
    neg(); rts_bit = 0;
    posn(5);
    chk({3'b0, rts_n}, 4'd0, "R6 held until empty");
    neg(); tx_empty = 1;
    posn(1);
    chk({3'b0, rts_n}, 4'd1, "R6 released");

    // R7 flag hold
    neg(); async_m = 0; bitsync_m = 1; fhold = 1; rts_bit = 1; tx_empty = 0;
    posn(1);
    neg(); rts_bit = 0; tx_empty = 1;
    posn(4);
    chk({3'b0, rts_n}, 4'd0, "R7 held, empty ignored");
    neg(); fdone = 1;
    neg(); fdone = 0;
    #1;
    chk({3'b0, rts_n}, 4'd1, "R7 released on flag");

    // R8 immediate release
    neg(); fhold = 0; rts_bit = 1;
    posn(1);
    neg(); rts_bit = 0;
    posn(1);
    chk({3'b0, rts_n}, 4'd1, "R8 immediate release");

    finish_run();
  end
endmodule